// File: doc/BRIEF.md
# Carry-Select Binary Adder

This block is a purely combinational unsigned adder of configurable width. It takes two operands and a carry-in and returns the sum and the carry-out. The operand width is cut into equal segments. Each segment is a chain of one-bit full adders.

The least significant segment adds directly with the external carry-in. Every segment above it holds two speculative copies. One copy assumes an incoming carry of zero and the other assumes one. When the true carry from below arrives, it only steers a multiplexer between the two results that are already settled. The critical path is therefore one segment ripple plus one multiplexer per higher segment, instead of a ripple through every bit.

It is meant to be dropped into wider datapaths where a single long ripple chain would be too slow. The segment size can then be tuned against the multiplexer count.

Top module: `csa_adder_top`

## Requirements
- R1: `sum_out` equals (`op_a` + `op_b` + `carry_in`) modulo 2^WIDTH for every input combination.
- R2: `carry_out` equals bit WIDTH of the full (WIDTH+1)-bit result of `op_a` + `op_b` + `carry_in`.
- R3: The lowest segment (bits SEG_W-1..0) is a single full-adder ripple chain fed by `carry_in`; its sum bits never depend on operand bits above it.
- R4: Each higher segment computes two candidate results, one for carry 0 and one for carry 1. The carry-1 sum equals the carry-0 sum plus one, modulo 2^SEG_W. The carry-1 carry-out is set whenever the carry-0 carry-out is set.
- R5: The true carry leaving the segment below selects both the sum bits and the outgoing carry of the current segment. A carry generated in a low segment must reach the bits above it.
- R6: WIDTH must be a positive integer multiple of SEG_W; any other setting stops elaboration.
- R7: The default configuration is WIDTH=8 built from two segments of SEG_W=4.
- R8: A carry-in that propagates across all segments (op_a all ones, op_b zero, carry_in 1) yields a zero sum and carry_out 1.
- R9: With WIDTH equal to SEG_W (a single segment) the block behaves as a plain ripple adder with the same results as R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| carry_in | input | 1 | Carry entering the least significant bit |
| sum_out | output | WIDTH | Sum modulo 2^WIDTH |
| carry_out | output | 1 | Carry leaving the most significant bit |

## Verification
The embedded checks compare each full adder, each ripple segment and the whole adder with an arithmetic sum of the same inputs. They also relate the two speculative copies of a segment to each other. These checks take for granted that all inputs are two-state values with no X or Z, because the arithmetic comparisons are meaningless on unknown bits. The stimulus drives only defined values, with fixed patterns, an exhaustive sweep and `$urandom` data. It waits a short settle time after each change before any output is read.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Number of segments for a given width and segment size.
  function automatic int unsigned seg_count(input int unsigned width, input int unsigned seg_w);
    return width / seg_w;
  endfunction

  // Nonzero when the width splits into whole segments.
  function automatic bit cfg_ok(input int unsigned width, input int unsigned seg_w);
    return (seg_w > 0) && (width >= seg_w) && ((width % seg_w) == 0);
  endfunction

endpackage

// File: rtl/csa_full_add.sv
module csa_full_add (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  logic half_p;

  assign half_p = x_i ^ y_i;
  assign s_o    = half_p ^ c_i;
  assign c_o    = (x_i & y_i) | (c_i & half_p);

  always_comb begin
    AST_FA_TRUTH: assert ({c_o, s_o} == (2'(x_i) + 2'(y_i) + 2'(c_i))); // R1
  end

endmodule

// File: rtl/csa_ripple_seg.sv
module csa_ripple_seg #(
  parameter int unsigned SEG_W = 4
) (
  input  logic [SEG_W-1:0] x_i,
  input  logic [SEG_W-1:0] y_i,
  input  logic             c_i,
  output logic [SEG_W-1:0] s_o,
  output logic             c_o
);

  logic [SEG_W:0] chain;

  assign chain[0] = c_i;

  for (genvar k = 0; k < SEG_W; k++) begin : g_bit
    csa_full_add u_fa (
      .x_i (x_i[k]),
      .y_i (y_i[k]),
      .c_i (chain[k]),
      .s_o (s_o[k]),
      .c_o (chain[k+1])
    );
  end

  assign c_o = chain[SEG_W];

  always_comb begin
    AST_SEG_RIPPLE: assert ({c_o, s_o} ==
      ({1'b0, x_i} + {1'b0, y_i} + (SEG_W+1)'(c_i))); // R3
  end

endmodule

// File: rtl/csa_spec_stage.sv
module csa_spec_stage #(
  parameter int unsigned SEG_W = 4
) (
  input  logic [SEG_W-1:0] x_i,
  input  logic [SEG_W-1:0] y_i,
  input  logic             sel_c_i,
  output logic [SEG_W-1:0] s_o,
  output logic             c_o
);

  logic [SEG_W-1:0] sum_c0;
  logic [SEG_W-1:0] sum_c1;
  logic             cy_c0;
  logic             cy_c1;

  csa_ripple_seg #(.SEG_W(SEG_W)) u_guess0 (
    .x_i (x_i),
    .y_i (y_i),
    .c_i (1'b0),
    .s_o (sum_c0),
    .c_o (cy_c0)
  );

  csa_ripple_seg #(.SEG_W(SEG_W)) u_guess1 (
    .x_i (x_i),
    .y_i (y_i),
    .c_i (1'b1),
    .s_o (sum_c1),
    .c_o (cy_c1)
  );

  always_comb begin
    if (sel_c_i) begin
      s_o = sum_c1;
      c_o = cy_c1;
    end else begin
      s_o = sum_c0;
      c_o = cy_c0;
    end
  end

  always_comb begin
    AST_SPEC_STEP:  assert (sum_c1 == (sum_c0 + SEG_W'(1)));  // R4
    AST_SPEC_ORDER: assert (cy_c1 || !cy_c0);                 // R4
  end

endmodule

// File: rtl/csa_adder_top.sv
module csa_adder_top #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SEG_W = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);

  import csa_pkg::*;

  localparam int unsigned NSEG = seg_count(WIDTH, SEG_W);

  // R6: reject widths that do not split into whole segments
  if (!cfg_ok(WIDTH, SEG_W)) begin : g_cfg_bad
    $error("csa_adder_top: WIDTH must be a positive multiple of SEG_W");
  end

  logic [NSEG:0] seg_cy;

  assign seg_cy[0] = carry_in;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    if (g == 0) begin : g_base
      csa_ripple_seg #(.SEG_W(SEG_W)) u_base (
        .x_i (op_a[SEG_W-1:0]),
        .y_i (op_b[SEG_W-1:0]),
        .c_i (seg_cy[0]),
        .s_o (sum_out[SEG_W-1:0]),
        .c_o (seg_cy[1])
      );
    end else begin : g_spec
      csa_spec_stage #(.SEG_W(SEG_W)) u_stage (
        .x_i     (op_a[g*SEG_W +: SEG_W]),
        .y_i     (op_b[g*SEG_W +: SEG_W]),
        .sel_c_i (seg_cy[g]),
        .s_o     (sum_out[g*SEG_W +: SEG_W]),
        .c_o     (seg_cy[g+1])
      );
    end
  end

  assign carry_out = seg_cy[NSEG];

  always_comb begin
    AST_SUM_MATCH: assert ({carry_out, sum_out} ==
      ({1'b0, op_a} + {1'b0, op_b} + (WIDTH+1)'(carry_in))); // R1
  end

endmodule

// File: tb/csa_adder_top_bench.sv
module csa_adder_top_bench;

  logic clk;
  logic rst_n;
  int   n_chk;
  int   n_bad;
  bit   done;

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // Default 8-bit instance (R7)
  logic [7:0]  a8, b8, s8;
  logic        c8, co8;
  csa_adder_top u_csa_adder_top (
    .op_a(a8), .op_b(b8), .carry_in(c8), .sum_out(s8), .carry_out(co8)
  );

  // 32-bit instance, 8-bit segments
  logic [31:0] a32, b32, s32;
  logic        c32, co32;
  csa_adder_top #(.WIDTH(32), .SEG_W(8)) u_wide (
    .op_a(a32), .op_b(b32), .carry_in(c32), .sum_out(s32), .carry_out(co32)
  );

  // Single-segment instance (R9)
  logic [3:0]  a4, b4, s4;
  logic        c4, co4;
  csa_adder_top #(.WIDTH(4), .SEG_W(4)) u_single (
    .op_a(a4), .op_b(b4), .carry_in(c4), .sum_out(s4), .carry_out(co4)
  );

  // {a, b, cin, expected sum, expected cout}
  localparam int NVEC = 8;
  localparam logic [97:0] VEC [NVEC] = '{
    {32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1},
    {32'h0000_00FF, 32'h0000_0001, 1'b0, 32'h0000_0100, 1'b0},
    {32'h1234_5678, 32'h8765_4321, 1'b0, 32'h9999_9999, 1'b0},
    {32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1},
    {32'h00FF_FFFF, 32'h0000_0000, 1'b1, 32'h0100_0000, 1'b0},
    {32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 32'h8000_0000, 1'b0}
  };

  task automatic chk(input string req, input logic [32:0] got, input logic [32:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog got=hung exp=complete");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a32 = '0; b32 = '0; c32 = 1'b0;
    a4 = '0; b4 = '0; c4 = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // Idle state: all-zero inputs give a zero result (R1, R2)
    @(negedge clk);
    chk("R1 idle sum8", {24'd0, co8, s8}, 33'd0);
    chk("R2 idle sum32", {co32, s32}, 33'd0);

    // Table of 32-bit patterns (R1, R2, R5, R8)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      a32 = VEC[i][97:66];
      b32 = VEC[i][65:34];
      c32 = VEC[i][33];
      #2;
      chk("R1_R2_R5 table", {co32, s32}, {VEC[i][0], VEC[i][32:1]});
    end

    // Exhaustive 8-bit sweep against behavioural sum (R1, R2, R5, R7)
    for (int ci = 0; ci < 2; ci++) begin
      for (int ia = 0; ia < 256; ia++) begin
        for (int ib = 0; ib < 256; ib++) begin
          a8 = ia[7:0]; b8 = ib[7:0]; c8 = ci[0];
          #1;
          chk("R1_R7 exhaustive8", {24'd0, co8, s8},
              33'(ia) + 33'(ib) + 33'(ci));
        end
      end
    end

    // Random 32-bit vectors (R1, R2, R4)
    for (int i = 0; i < 3000; i++) begin
      a32 = $urandom; b32 = $urandom; c32 = 1'($urandom);
      #1;
      chk("R1_R4 random32", {co32, s32}, {1'b0, a32} + {1'b0, b32} + 33'(c32));
    end

    // R3: low segment result ignores upper operand bits
    a8 = 8'h05; b8 = 8'h03; c8 = 1'b1; #1;
    chk("R3 low only", {29'd0, s8[3:0]}, 33'd9);
    a8 = 8'hF5; b8 = 8'hA3; c8 = 1'b1; #1;
    chk("R3 low with upper noise", {29'd0, s8[3:0]}, 33'd9);

    // R5: carry from low segment selects upper candidate
    a8 = 8'h0F; b8 = 8'h01; c8 = 1'b0; #1;
    chk("R5 select carry", {24'd0, co8, s8}, 33'h010);
    a8 = 8'hF0; b8 = 8'h0F; c8 = 1'b1; #1;
    chk("R5 double select", {24'd0, co8, s8}, 33'h100);

    // R8: full propagation on default and wide instances
    a8 = 8'hFF; b8 = 8'h00; c8 = 1'b1; #1;
    chk("R8 full chain8", {24'd0, co8, s8}, 33'h100);
    a32 = 32'hFFFF_FFFF; b32 = 32'h0; c32 = 1'b1; #1;
    chk("R8 full chain32", {co32, s32}, 33'h1_0000_0000);

    // R9: single segment exhaustive
    for (int ci = 0; ci < 2; ci++) begin
      for (int ia = 0; ia < 16; ia++) begin
        for (int ib = 0; ib < 16; ib++) begin
          a4 = ia[3:0]; b4 = ib[3:0]; c4 = ci[0];
          #1;
          chk("R9 single seg", {28'd0, co4, s4}, 33'(ia) + 33'(ib) + 33'(ci));
        end
      end
    end

    // R6 is an elaboration rule; the legal configs above all build.
    finish_run();
  end

endmodule